// File: doc/BRIEF.md
# Table Pointer and Write-Buffer Unit

This unit owns a 22-bit byte pointer into program memory and moves single bytes between that memory and an 8-bit transfer latch. A CPU front end issues commands on one valid/ready command port: it loads the pointer one byte register at a time, loads the latch, starts a table read (memory byte into the latch), or starts a table write (latch byte into one of eight holding registers). Reads and writes each carry one of four pointer-update modes. Bits 20:0 of the pointer address up to 2 MB of program memory. Bit 21 selects a separate space that holds the ID and configuration locations. The increment and decrement modes touch only bits 20:0, so the low 21 bits wrap on their own.

Two further commands ask the flash controller to act. A long-write command raises a one-cycle request that carries the 8-byte-aligned block address and all eight holding-register bytes. An erase command raises a one-cycle request that carries the 64-byte-aligned block address. While the controller reports busy, the unit deasserts `cmd_ready`. A command held on `cmd_valid` is taken on the first rising edge where `cmd_valid` and `cmd_ready` are both high. Until then it has no effect. Table reads use a synchronous memory read port: the memory registers its data on the edge where the read is accepted.

Top module: `table_ptr_unit`

## Requirements
- R1: A synchronous active-high `rst` clears the pointer, the latch and all eight holding registers to zero. No request is raised during or right after reset.
- R2: `cmd_op` 0, 1 and 2 load `cmd_data` into pointer bits 7:0, 15:8 and 21:16. For op 2 only `cmd_data[5:0]` is used and bits 7:6 are ignored. The new value shows on `ptr_value` after the accepting edge.
- R3: `cmd_op` 4 (table read) drives `mem_rd_en` high in the accepting cycle, with `mem_rd_addr` set to the full 22-bit access address. The byte returned is on `latch_data` one clock after the accepting edge and stays there.
- R4: `cmd_mode` on ops 4 and 5 selects the update. 0 leaves the pointer unchanged. 1 accesses with the old value and then adds one. 2 accesses with the old value and then subtracts one. 3 adds one first and accesses with the new value. The pointer changes at the accepting edge.
- R5: The increment and decrement never alter pointer bit 21. Bits 20:0 wrap from 0x1FFFFF to 0 and from 0 to 0x1FFFFF.
- R6: `cmd_op` 5 (table write) copies the latch into holding register number access-address[2:0]. The other seven holding registers keep their values.
- R7: `cmd_op` 6 (long write) raises `lw_req` for exactly the one cycle after the accepting edge. During that cycle `lw_addr` is the pointer with bits 2:0 cleared, and `lw_data[8k+7:8k]` is holding register k. The pointer does not change.
- R8: `cmd_op` 7 (erase) raises `er_req` for exactly the one cycle after the accepting edge, with `er_addr` equal to the pointer with bits 5:0 cleared. The pointer does not change.
- R9: While `flash_busy` is high, `cmd_ready` is low. No command is accepted, `mem_rd_en` stays low and the pointer holds its value.
- R10: `cmd_op` 3 loads `cmd_data` into the latch, and `latch_data` shows it after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can accept a command |
| cmd_op | input | 3 | Operation code (see R2, R3, R6, R7, R8, R10) |
| cmd_mode | input | 2 | Pointer-update mode for ops 4 and 5 |
| cmd_data | input | 8 | Byte for pointer or latch loads |
| flash_busy | input | 1 | Flash controller busy, stalls commands |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 22 | Memory read byte address |
| mem_rd_data | input | 8 | Byte registered by memory on the read edge |
| latch_data | output | 8 | Transfer latch contents |
| ptr_value | output | 22 | Current pointer |
| lw_req | output | 1 | Long-write request, one cycle |
| lw_addr | output | 22 | 8-byte-aligned long-write address |
| lw_data | output | 64 | Eight holding-register bytes |
| er_req | output | 1 | Erase request, one cycle |
| er_addr | output | 22 | 64-byte-aligned erase address |

## Verification
The bench drives the pointer across both wrap points with bit 21 clear and with it set. A design that carried into bit 21 or borrowed out of it would land in the wrong space. It compares the pre-increment access address with the post-increment one: a design that used the old pointer for the pre-increment mode would read and write one byte too low. It fills the holding registers through post-increment and pre-increment writes, then checks the exact byte order of the long-write word and the alignment of both request addresses. Shifted lanes or unmasked low bits would show up there. It also holds a read under busy and checks that nothing moves until busy drops, and that reset empties the holding registers.

// File: rtl/tpu_pkg.sv
package tpu_pkg;
  typedef enum logic [2:0] {
    OP_LD_LO  = 3'd0,
    OP_LD_HI  = 3'd1,
    OP_LD_UP  = 3'd2,
    OP_LD_LAT = 3'd3,
    OP_TRD    = 3'd4,
    OP_TWR    = 3'd5,
    OP_LONGWR = 3'd6,
    OP_ERASE  = 3'd7
  } tpu_op_e;

  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,
    UPD_POSTINC = 2'd1,
    UPD_POSTDEC = 2'd2,
    UPD_PREINC  = 2'd3
  } tpu_upd_e;
endpackage

// File: rtl/tpu_ptr.sv
module tpu_ptr #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              ld_up,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              step_en,
  input  logic [1:0]        upd,
  output logic [ADDR_W-1:0] ptr_q,
  output logic [ADDR_W-1:0] acc_addr
);
  import tpu_pkg::*;
  localparam int LOW_W = ADDR_W - 1;
  localparam int UP_W  = ADDR_W - 2 * DATA_W;

  logic [ADDR_W-1:0] inc_v, dec_v, nxt;

  // the space-select bit is carried through untouched
  always_comb begin
    inc_v = {ptr_q[ADDR_W-1], ptr_q[LOW_W-1:0] + LOW_W'(1)};
    dec_v = {ptr_q[ADDR_W-1], ptr_q[LOW_W-1:0] - LOW_W'(1)};
    acc_addr = (tpu_upd_e'(upd) == UPD_PREINC) ? inc_v : ptr_q;
    nxt = ptr_q;
    if (step_en) begin
      unique case (tpu_upd_e'(upd))
        UPD_NONE:    nxt = ptr_q;
        UPD_POSTINC: nxt = inc_v;
        UPD_POSTDEC: nxt = dec_v;
        UPD_PREINC:  nxt = inc_v;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (ld_lo) begin
      ptr_q[DATA_W-1:0] <= ld_data;
    end else if (ld_hi) begin
      ptr_q[2*DATA_W-1:DATA_W] <= ld_data;
    end else if (ld_up) begin
      ptr_q[ADDR_W-1:2*DATA_W] <= ld_data[UP_W-1:0];
    end else begin
      ptr_q <= nxt;
    end
  end
endmodule

// File: rtl/tpu_hold.sv
module tpu_hold #(
  parameter int HOLD_N = 8,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [$clog2(HOLD_N)-1:0]  wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [HOLD_N*DATA_W-1:0]   hold_flat
);
  localparam int IDX_W = $clog2(HOLD_N);

  for (genvar k = 0; k < HOLD_N; k++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(k))) begin
        slot_q <= wr_data;
      end
    end
    assign hold_flat[k*DATA_W +: DATA_W] = slot_q;
  end
endmodule

// File: rtl/tpu_latch.sv
module tpu_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              rd_arm,
  input  logic [DATA_W-1:0] mem_data,
  output logic [DATA_W-1:0] latch_out
);
  logic              rd_pend;
  logic [DATA_W-1:0] lat_q;

  // memory output is taken directly in the cycle after the read edge
  assign latch_out = rd_pend ? mem_data : lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= 1'b0;
      lat_q   <= '0;
    end else begin
      rd_pend <= rd_arm;
      lat_q   <= ld_en ? ld_data : latch_out;
    end
  end
endmodule

// File: rtl/tpu_req.sv
module tpu_req #(
  parameter int ADDR_W   = 22,
  parameter int WB_LSB   = 3,
  parameter int EB_LSB   = 6,
  parameter int BUF_W    = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     lw_go,
  input  logic                     er_go,
  input  logic [ADDR_W-WB_LSB-1:0] blk_ptr,
  input  logic [BUF_W-1:0]         hold_flat,
  output logic                     lw_req,
  output logic [ADDR_W-1:0]        lw_addr,
  output logic [BUF_W-1:0]         lw_data,
  output logic                     er_req,
  output logic [ADDR_W-1:0]        er_addr
);
  localparam int GAP = EB_LSB - WB_LSB;

  always_ff @(posedge clk) begin
    if (rst) begin
      lw_req  <= 1'b0;
      er_req  <= 1'b0;
      lw_addr <= '0;
      lw_data <= '0;
      er_addr <= '0;
    end else begin
      lw_req <= lw_go;
      er_req <= er_go;
      if (lw_go) begin
        lw_addr <= {blk_ptr, WB_LSB'(0)};
        lw_data <= hold_flat;
      end
      if (er_go) begin
        er_addr <= {blk_ptr[ADDR_W-WB_LSB-1:GAP], EB_LSB'(0)};
      end
    end
  end
endmodule

// File: rtl/table_ptr_unit.sv
module table_ptr_unit #(
  parameter int ADDR_W      = 22,
  parameter int DATA_W      = 8,
  parameter int HOLD_N      = 8,
  parameter int ERASE_BYTES = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [2:0]               cmd_op,
  input  logic [1:0]               cmd_mode,
  input  logic [DATA_W-1:0]        cmd_data,
  input  logic                     flash_busy,
  output logic                     mem_rd_en,
  output logic [ADDR_W-1:0]        mem_rd_addr,
  input  logic [DATA_W-1:0]        mem_rd_data,
  output logic [DATA_W-1:0]        latch_data,
  output logic [ADDR_W-1:0]        ptr_value,
  output logic                     lw_req,
  output logic [ADDR_W-1:0]        lw_addr,
  output logic [HOLD_N*DATA_W-1:0] lw_data,
  output logic                     er_req,
  output logic [ADDR_W-1:0]        er_addr
);
  import tpu_pkg::*;
  localparam int IDX_W  = $clog2(HOLD_N);
  localparam int EB_LSB = $clog2(ERASE_BYTES);
  localparam int BUF_W  = HOLD_N * DATA_W;

  logic              take;
  tpu_op_e           op;
  logic              is_rd, is_wr;
  logic [ADDR_W-1:0] acc_addr;
  logic [BUF_W-1:0]  hold_flat;

  assign cmd_ready = ~flash_busy;
  assign take      = cmd_valid & cmd_ready;
  assign op        = tpu_op_e'(cmd_op);
  assign is_rd     = take && (op == OP_TRD);
  assign is_wr     = take && (op == OP_TWR);

  assign mem_rd_en   = is_rd;
  assign mem_rd_addr = acc_addr;

  tpu_ptr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptr (
    .clk(clk), .rst(rst),
    .ld_lo(take && (op == OP_LD_LO)),
    .ld_hi(take && (op == OP_LD_HI)),
    .ld_up(take && (op == OP_LD_UP)),
    .ld_data(cmd_data),
    .step_en(is_rd | is_wr),
    .upd(cmd_mode),
    .ptr_q(ptr_value),
    .acc_addr(acc_addr)
  );

  tpu_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst),
    .ld_en(take && (op == OP_LD_LAT)),
    .ld_data(cmd_data),
    .rd_arm(is_rd),
    .mem_data(mem_rd_data),
    .latch_out(latch_data)
  );

  tpu_hold #(.HOLD_N(HOLD_N), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst),
    .wr_en(is_wr),
    .wr_idx(acc_addr[IDX_W-1:0]),
    .wr_data(latch_data),
    .hold_flat(hold_flat)
  );

  tpu_req #(.ADDR_W(ADDR_W), .WB_LSB(IDX_W), .EB_LSB(EB_LSB), .BUF_W(BUF_W)) u_req (
    .clk(clk), .rst(rst),
    .lw_go(take && (op == OP_LONGWR)),
    .er_go(take && (op == OP_ERASE)),
    .blk_ptr(ptr_value[ADDR_W-1:IDX_W]),
    .hold_flat(hold_flat),
    .lw_req(lw_req), .lw_addr(lw_addr), .lw_data(lw_data),
    .er_req(er_req), .er_addr(er_addr)
  );
endmodule

// File: rtl/tpu_chk.sv
module tpu_chk #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [1:0]        cmd_mode,
  input logic              flash_busy,
  input logic              mem_rd_en,
  input logic [DATA_W-1:0] latch_data,
  input logic [ADDR_W-1:0] ptr_value,
  input logic              lw_req,
  input logic [ADDR_W-1:0] lw_addr,
  input logic              er_req,
  input logic [ADDR_W-1:0] er_addr
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (ptr_value == '0 && latch_data == '0 && !lw_req && !er_req)); // R1
  AST_RD_STROBE: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 3'd4) |-> mem_rd_en); // R3
  AST_MODE0_HOLD: assert property (@(posedge clk) disable iff (rst)
    (acc && (cmd_op == 3'd4 || cmd_op == 3'd5) && cmd_mode == 2'd0) |=> $stable(ptr_value)); // R4
  AST_SPACE_BIT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (acc && (cmd_op == 3'd4 || cmd_op == 3'd5)) |=> (ptr_value[ADDR_W-1] == $past(ptr_value[ADDR_W-1]))); // R5
  AST_LW_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 3'd6) |=> (lw_req && lw_addr[2:0] == 3'b000)); // R7
  AST_ER_ONLY_ON_CMD: assert property (@(posedge clk) disable iff (rst)
    er_req |-> ($past(acc && cmd_op == 3'd7) && er_addr[5:0] == 6'd0)); // R8
  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (rst)
    flash_busy |-> (!cmd_ready && !mem_rd_en)); // R9
  AST_IDLE_PTR_STABLE: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(ptr_value)); // R9
endmodule

bind table_ptr_unit tpu_chk i_tpu_chk (.*);

// File: tb/test_table_ptr_unit.sv
module test_table_ptr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_mode = '0;
  logic [7:0]  cmd_data = '0;
  logic        flash_busy = 1'b0;
  logic        mem_rd_en;
  logic [21:0] mem_rd_addr;
  logic [7:0]  mem_rd_data = '0;
  logic [7:0]  latch_data;
  logic [21:0] ptr_value;
  logic        lw_req;
  logic [21:0] lw_addr;
  logic [63:0] lw_data;
  logic        er_req;
  logic [21:0] er_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  table_ptr_unit i_table_ptr_unit (.*);

  function automatic logic [7:0] memfn(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= memfn(mem_rd_addr);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic issue(input logic [2:0] op, input logic [1:0] md, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_mode = md; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic set_ptr(input logic [21:0] p);
    issue(3'd2, 2'd0, {2'b00, p[21:16]});
    issue(3'd1, 2'd0, p[15:8]);
    issue(3'd0, 2'd0, p[7:0]);
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  md;
    logic [7:0]  d;
    logic [21:0] exp_ptr;
    logic        rd;
    logic [21:0] rd_addr;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{3'd0, 2'd0, 8'h34, 22'h000034, 1'b0, 22'h0},       // R2 low byte
    '{3'd1, 2'd0, 8'h12, 22'h001234, 1'b0, 22'h0},       // R2 high byte
    '{3'd2, 2'd0, 8'hFF, 22'h3F1234, 1'b0, 22'h0},       // R2 upper, bits 7:6 ignored
    '{3'd4, 2'd1, 8'h00, 22'h3F1235, 1'b1, 22'h3F1234},  // R4 post-inc
    '{3'd4, 2'd2, 8'h00, 22'h3F1234, 1'b1, 22'h3F1235},  // R4 post-dec
    '{3'd4, 2'd3, 8'h00, 22'h3F1235, 1'b1, 22'h3F1235},  // R4 pre-inc
    '{3'd4, 2'd0, 8'h00, 22'h3F1235, 1'b1, 22'h3F1235},  // R4 no change
    '{3'd2, 2'd0, 8'h1F, 22'h1F1235, 1'b0, 22'h0},
    '{3'd1, 2'd0, 8'hFF, 22'h1FFF35, 1'b0, 22'h0},
    '{3'd0, 2'd0, 8'hFF, 22'h1FFFFF, 1'b0, 22'h0},
    '{3'd4, 2'd1, 8'h00, 22'h000000, 1'b1, 22'h1FFFFF},  // R5 wrap up
    '{3'd4, 2'd2, 8'h00, 22'h1FFFFF, 1'b1, 22'h000000},  // R5 wrap down
    '{3'd2, 2'd0, 8'h20, 22'h20FFFF, 1'b0, 22'h0},
    '{3'd1, 2'd0, 8'h00, 22'h2000FF, 1'b0, 22'h0},
    '{3'd0, 2'd0, 8'h00, 22'h200000, 1'b0, 22'h0},
    '{3'd4, 2'd2, 8'h00, 22'h3FFFFF, 1'b1, 22'h200000}   // R5 bit 21 kept
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] exp_buf;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(ptr_value == 0, "R1 ptr", 64'(ptr_value), 0);
    chk(latch_data == 0, "R1 latch", 64'(latch_data), 0);
    chk(!lw_req && !er_req, "R1 req", {lw_req, er_req}, 0);
    chk(cmd_ready == 1'b1, "R9 ready idle", 64'(cmd_ready), 1);

    for (int i = 0; i < 16; i++) begin
      cmd_valid = 1'b1; cmd_op = VEC[i].op; cmd_mode = VEC[i].md; cmd_data = VEC[i].d;
      #1;
      if (VEC[i].rd) begin
        chk(mem_rd_en == 1'b1, "R3 strobe", 64'(mem_rd_en), 1);
        chk(mem_rd_addr == VEC[i].rd_addr, "R3/R4 addr", 64'(mem_rd_addr), 64'(VEC[i].rd_addr));
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(ptr_value == VEC[i].exp_ptr, "R2/R4/R5 ptr", 64'(ptr_value), 64'(VEC[i].exp_ptr));
      if (VEC[i].rd)
        chk(latch_data == memfn(VEC[i].rd_addr), "R3 latch", 64'(latch_data), 64'(memfn(VEC[i].rd_addr)));
    end
    @(negedge clk);
    chk(latch_data == memfn(22'h200000), "R3 latch held", 64'(latch_data), 64'(memfn(22'h200000)));

    // R6 fill holding registers with post-increment writes
    set_ptr(22'h001238);
    for (int k = 0; k < 8; k++) begin
      issue(3'd3, 2'd0, 8'hA0 + 8'(k));
      chk(latch_data == 8'hA0 + 8'(k), "R10 latch load", 64'(latch_data), 64'(8'hA0 + 8'(k)));
      issue(3'd5, 2'd1, 8'h00);
      chk(ptr_value == 22'h001239 + 22'(k), "R4 write post-inc", 64'(ptr_value), 64'(22'h001239 + 22'(k)));
    end
    // pre-increment write lands in slot 1
    issue(3'd3, 2'd0, 8'hEE);
    issue(3'd5, 2'd3, 8'h00);
    chk(ptr_value == 22'h001241, "R4 write pre-inc", 64'(ptr_value), 64'h001241);
    issue(3'd6, 2'd0, 8'h00);
    exp_buf = 64'hA7A6A5A4A3A2EEA0;
    chk(lw_req == 1'b1, "R7 req", 64'(lw_req), 1);
    chk(lw_addr == 22'h001240, "R7 addr", 64'(lw_addr), 64'h001240);
    chk(lw_data == exp_buf, "R6/R7 data", lw_data, exp_buf);
    chk(er_req == 1'b0, "R8 no erase", 64'(er_req), 0);
    chk(ptr_value == 22'h001241, "R7 ptr kept", 64'(ptr_value), 64'h001241);
    @(negedge clk);
    chk(lw_req == 1'b0, "R7 one cycle", 64'(lw_req), 0);

    // R8 erase alignment
    set_ptr(22'h3ABCDE);
    issue(3'd7, 2'd0, 8'h00);
    chk(er_req == 1'b1, "R8 req", 64'(er_req), 1);
    chk(er_addr == 22'h3ABCC0, "R8 addr", 64'(er_addr), 64'h3ABCC0);
    chk(ptr_value == 22'h3ABCDE, "R8 ptr kept", 64'(ptr_value), 64'h3ABCDE);
    @(negedge clk);
    chk(er_req == 1'b0, "R8 one cycle", 64'(er_req), 0);
    issue(3'd6, 2'd0, 8'h00);
    chk(lw_addr == 22'h3ABCD8, "R7 addr high", 64'(lw_addr), 64'h3ABCD8);

    // R9 busy stall with a held read
    flash_busy = 1'b1;
    cmd_valid = 1'b1; cmd_op = 3'd4; cmd_mode = 2'd1; cmd_data = 8'h00;
    #1;
    chk(cmd_ready == 1'b0, "R9 ready low", 64'(cmd_ready), 0);
    chk(mem_rd_en == 1'b0, "R9 no strobe", 64'(mem_rd_en), 0);
    @(negedge clk);
    chk(ptr_value == 22'h3ABCDE, "R9 ptr held", 64'(ptr_value), 64'h3ABCDE);
    flash_busy = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(ptr_value == 22'h3ABCDF, "R9 taken after busy", 64'(ptr_value), 64'h3ABCDF);
    chk(latch_data == memfn(22'h3ABCDE), "R3 latch after stall", 64'(latch_data), 64'(memfn(22'h3ABCDE)));

    // R1 reset empties everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(ptr_value == 0, "R1 ptr after reset", 64'(ptr_value), 0);
    chk(latch_data == 0, "R1 latch after reset", 64'(latch_data), 0);
    issue(3'd6, 2'd0, 8'h00);
    chk(lw_data == 64'h0, "R1 holding cleared", lw_data, 0);
    chk(lw_addr == 22'h0, "R1 lw addr", 64'(lw_addr), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule